// File: doc/BRIEF.md
# Mode-banked processor register file

This block stores the sixteen architectural registers of a 32-bit processor core together with its status register and the saved status registers of the exception modes. Two combinational read ports and one clocked write port are all addressed by architectural register number (0 to 15). The current processor mode is taken from the low four bits of the status register. That mode decides which physical copy serves each address, so an exception handler sees its own high registers without any software save or restore.

Registers 0 to 7 and register 15 (the program counter) each have one physical copy. The fast-interrupt mode has a private set of registers 8 to 12. Each of the five exception modes has its own registers 13 and 14 and its own saved status register. The user mode, and any mode code that is not listed, uses the user copies and has no saved status register. A mode-set request rewrites the status register's mode field. Instruction decode, exception entry sequencing and the program-counter increment belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0–7 and 15 have one physical copy each. A value written in any mode reads back unchanged in every other mode.
- R2: With mode code 0x1 (fast interrupt), registers 8–12 map to a private set. Every other mode code shares one common set of registers 8–12.
- R3: Mode codes 0x1, 0x2 (interrupt), 0x3 (supervisor), 0x7 (abort) and 0xB (undefined) each have a private register 13 and 14. Mode code 0x0 (user) and every unlisted code use the user copies.
- R4: Each of the five exception mode codes owns one saved status register. The saved-status read port and write port act on the register of the current mode.
- R5: In user mode or an unlisted mode, the saved-status read returns zero and the absent flag is 1. A saved-status write in that state changes no saved status register.
- R6: A mode-set request makes status bits [4:0] equal to 1 followed by the 4-bit code (0x10 OR code) from the next cycle on. All other status bits keep their value, and `mode_field` shows bits [4:0].
- R7: A full status write replaces every status bit. When it coincides with a mode-set request, the mode-set value wins for bits [4:0].
- R8: A register or saved-status write in the same cycle as a mode change goes to the bank of the mode that was current before the change.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible after the clock edge.
- R10: A synchronous active-low reset clears every physical register, the status register and all saved status registers. After reset the mode is user.
- R11: The two read ports select independently and may read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_addr | input | 4 | Read port A architectural register number |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_addr | input | 4 | Read port B architectural register number |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Write port architectural register number |
| wr_data | input | DATA_W | Write data |
| mode_set | input | 1 | Request to load a new mode code |
| mode_code | input | 4 | New 4-bit mode code |
| sr_wr_en | input | 1 | Full status register write enable |
| sr_wr_data | input | DATA_W | Status register write data |
| sr_q | output | DATA_W | Current status register |
| mode_field | output | 5 | Status register bits [4:0] |
| ssr_wr_en | input | 1 | Saved status write enable (current mode) |
| ssr_wr_data | input | DATA_W | Saved status write data |
| ssr_rd_data | output | DATA_W | Saved status of current mode, zero if absent |
| ssr_absent | output | 1 | Current mode has no saved status register |

## Verification
The bench uses the default DATA_W of 32. At that width the upper status bits above the mode field can be checked for preservation, and saved-status values that differ in every nibble can be told apart. It drives all six listed mode codes and the unlisted code 0x5, so all 31 physical registers are reached through the two read ports. The same-cycle cases are covered as well: write with mode change, read during write, and status write with mode set.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and mode decoding for the banked register file.
// Assumes a 4-bit mode code held in status bits [3:0], bit 4 set by mode-set.
package bankreg_pkg;

    localparam int ARCH_AW   = 4;
    localparam int MODE_W    = 4;
    localparam int FIELD_W   = MODE_W + 1;
    localparam int N_SAVED   = 5;
    // physical layout: 0-15 user view, 16-20 fast r8-r12, 21-30 private r13/r14 pairs
    localparam int FAST_BASE = 16;
    localparam int FAST_CNT  = 5;
    localparam int PRIV_BASE = FAST_BASE + FAST_CNT;
    localparam int NPHYS     = PRIV_BASE + 2 * N_SAVED;
    localparam int PIDX_W    = $clog2(NPHYS);
    localparam int SLOT_W    = $clog2(N_SAVED);

    localparam logic [MODE_W-1:0] MD_USER  = 4'h0;
    localparam logic [MODE_W-1:0] MD_FAST  = 4'h1;
    localparam logic [MODE_W-1:0] MD_IRQ   = 4'h2;
    localparam logic [MODE_W-1:0] MD_SUPV  = 4'h3;
    localparam logic [MODE_W-1:0] MD_ABORT = 4'h7;
    localparam logic [MODE_W-1:0] MD_UNDEF = 4'hB;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } slot_t;

    // Map a mode code to its private slot (r13/r14/saved status), if any.
    function automatic slot_t mode_slot(input logic [MODE_W-1:0] code);
        slot_t s;
        s.hit  = 1'b1;
        s.slot = '0;
        case (code)
            MD_FAST:  s.slot = SLOT_W'(0);
            MD_IRQ:   s.slot = SLOT_W'(1);
            MD_SUPV:  s.slot = SLOT_W'(2);
            MD_ABORT: s.slot = SLOT_W'(3);
            MD_UNDEF: s.slot = SLOT_W'(4);
            default:  s.hit  = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bank_map.sv
`timescale 1ns/1ps
// Module: bank_map
// Translates an architectural register number into a physical index under
// the given mode code. Purely combinational. Assumes the physical layout
// defined in bankreg_pkg.
module bank_map
    import bankreg_pkg::*;
(
    input  logic [MODE_W-1:0]  mode,
    input  logic [ARCH_AW-1:0] arch_addr,
    output logic [PIDX_W-1:0]  phys_idx
);

    slot_t slot;
    logic  is_hi_gp;
    logic  is_sp_lr;

    // Classify the address and pick the bank it lives in.
    always_comb begin
        slot     = mode_slot(mode);
        is_hi_gp = (arch_addr >= ARCH_AW'(8)) && (arch_addr <= ARCH_AW'(12));
        is_sp_lr = (arch_addr == ARCH_AW'(13)) || (arch_addr == ARCH_AW'(14));
        phys_idx = PIDX_W'(arch_addr);
        if (is_hi_gp && (mode == MD_FAST)) begin
            phys_idx = PIDX_W'(FAST_BASE + int'(arch_addr) - 8);
        end else if (is_sp_lr && slot.hit) begin
            phys_idx = PIDX_W'(PRIV_BASE + 2 * int'(slot.slot) + int'(arch_addr) - 13);
        end
    end

endmodule

// File: rtl/phys_regs.sv
`timescale 1ns/1ps
// Module: phys_regs
// Physical register storage: NPHYS words, one clocked write port and
// NRD combinational read ports addressed by physical index. Reads see the
// value held before a same-cycle write. Assumes indices below NPHYS.
module phys_regs
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PIDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NRD-1:0][PIDX_W-1:0]   rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data
);

    logic [NPHYS-1:0][DATA_W-1:0] store_q;

    for (genvar e = 0; e < NPHYS; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == PIDX_W'(e));
        // Hold or load one physical word; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)   store_q[e] <= '0;
            else if (hit) store_q[e] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Combinational read mux for one port.
        always_comb begin
            rd_data[p] = '0;
            for (int e = 0; e < NPHYS; e++) begin
                if (rd_idx[p] == PIDX_W'(e)) rd_data[p] = store_q[e];
            end
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> store_q[$past(wr_idx)] == $past(wr_data)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store_q)); // R9

endmodule

// File: rtl/status_bank.sv
`timescale 1ns/1ps
// Module: status_bank
// Holds the status register and one saved status register per exception
// mode. The current mode is status bits [3:0]; mode-set overrides bits [4:0]
// of a coinciding full write. Saved-status access uses the mode current
// before the clock edge.
module status_bank
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_set,
    input  logic [MODE_W-1:0]  mode_code,
    input  logic               sr_wr_en,
    input  logic [DATA_W-1:0]  sr_wr_data,
    input  logic               ssr_wr_en,
    input  logic [DATA_W-1:0]  ssr_wr_data,
    output logic [DATA_W-1:0]  sr_q,
    output logic [MODE_W-1:0]  cur_mode,
    output logic [DATA_W-1:0]  ssr_rd_data,
    output logic               ssr_absent
);

    logic [DATA_W-1:0]              sr_r;
    logic [N_SAVED-1:0][DATA_W-1:0] saved_q;
    slot_t                          cur_slot;

    // Status register update: full write first, then mode field override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_r <= '0;
        end else begin
            if (sr_wr_en) sr_r <= sr_wr_data;
            if (mode_set) sr_r[FIELD_W-1:0] <= {1'b1, mode_code};
        end
    end

    assign sr_q     = sr_r;
    assign cur_mode = sr_r[MODE_W-1:0];
    assign cur_slot = mode_slot(cur_mode);

    for (genvar g = 0; g < N_SAVED; g++) begin : g_saved
        logic hit;
        assign hit = ssr_wr_en && cur_slot.hit && (cur_slot.slot == SLOT_W'(g));
        // One saved status register, written only in its own mode.
        always_ff @(posedge clk) begin
            if (!rst_n)   saved_q[g] <= '0;
            else if (hit) saved_q[g] <= ssr_wr_data;
        end
    end

    // Saved-status read for the current mode, zero when none exists.
    always_comb begin
        ssr_absent  = !cur_slot.hit;
        ssr_rd_data = '0;
        for (int g = 0; g < N_SAVED; g++) begin
            if (cur_slot.hit && (cur_slot.slot == SLOT_W'(g))) ssr_rd_data = saved_q[g];
        end
    end

    AST_MODE_FIELD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_set |=> sr_r[FIELD_W-1:0] == {1'b1, $past(mode_code)}); // R6

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_set && !sr_wr_en) |=> sr_r[DATA_W-1:FIELD_W] == $past(sr_r[DATA_W-1:FIELD_W])); // R6

    AST_ABSENT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ssr_wr_en && ssr_absent) |=> $stable(saved_q)); // R5

endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
// Module: banked_regfile (top)
// Mode-banked register file: two combinational read ports and one write
// port addressed by architectural number, mapped to physical storage by the
// current mode held in the status register. Assumes DATA_W >= 5.
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         rd_a_addr,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [3:0]         rd_b_addr,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               mode_set,
    input  logic [3:0]         mode_code,
    input  logic               sr_wr_en,
    input  logic [DATA_W-1:0]  sr_wr_data,
    output logic [DATA_W-1:0]  sr_q,
    output logic [4:0]         mode_field,
    input  logic               ssr_wr_en,
    input  logic [DATA_W-1:0]  ssr_wr_data,
    output logic [DATA_W-1:0]  ssr_rd_data,
    output logic               ssr_absent
);

    localparam int NRD   = 2;
    localparam int NMAP  = NRD + 1;
    localparam int WR_PT = NRD;

    logic [MODE_W-1:0]                cur_mode;
    logic [NMAP-1:0][ARCH_AW-1:0]     map_addr;
    logic [NMAP-1:0][PIDX_W-1:0]      map_idx;
    logic [NRD-1:0][PIDX_W-1:0]       rd_idx;
    logic [NRD-1:0][DATA_W-1:0]       rd_data;

    assign map_addr = {wr_addr, rd_b_addr, rd_a_addr};

    status_bank #(.DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_set    (mode_set),
        .mode_code   (mode_code),
        .sr_wr_en    (sr_wr_en),
        .sr_wr_data  (sr_wr_data),
        .ssr_wr_en   (ssr_wr_en),
        .ssr_wr_data (ssr_wr_data),
        .sr_q        (sr_q),
        .cur_mode    (cur_mode),
        .ssr_rd_data (ssr_rd_data),
        .ssr_absent  (ssr_absent)
    );

    for (genvar p = 0; p < NMAP; p++) begin : g_map
        bank_map u_map (
            .mode      (cur_mode),
            .arch_addr (map_addr[p]),
            .phys_idx  (map_idx[p])
        );
    end

    assign rd_idx = map_idx[NRD-1:0];

    phys_regs #(.DATA_W(DATA_W), .NRD(NRD)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (map_idx[WR_PT]),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];
    assign mode_field = sr_q[FIELD_W-1:0];

endmodule

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;

    localparam logic [3:0] USR = 4'h0, FIQ = 4'h1, IRQ = 4'h2, SVC = 4'h3,
                            ABT = 4'h7, UND = 4'hB, ODD = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0, mode_code = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sr_wr_data = '0, sr_q;
    logic [31:0] ssr_wr_data = '0, ssr_rd_data;
    logic        wr_en = 1'b0, mode_set = 1'b0, sr_wr_en = 1'b0, ssr_wr_en = 1'b0, ssr_absent;
    logic [4:0]  mode_field;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    banked_regfile #(.DATA_W(32)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] c);
        mode_set = 1'b1; mode_code = c;
        tick();
        mode_set = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_a_addr = a; rd_b_addr = a;
        #1;
        chk(req, rd_a_data, exp);
        chk(req, rd_b_data, exp);
    endtask

    task automatic ssr_wr(input logic [31:0] d);
        ssr_wr_en = 1'b1; ssr_wr_data = d;
        tick();
        ssr_wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        #1;
        chk("R10 status", sr_q, 32'h0);
        chk("R10 mode_field", {27'h0, mode_field}, 32'h0);
        chk("R10 absent", {31'h0, ssr_absent}, 32'h1);
        chk("R10 ssr", ssr_rd_data, 32'h0);
        for (int i = 0; i < 16; i++) rd("R10 reg", 4'(i), 32'h0);
    endtask

    task automatic t_shared();
        for (int i = 0; i < 8; i++) wr(4'(i), 32'h1000_0000 + i);
        wr(4'd15, 32'h0000_8000);
        set_mode(FIQ);
        for (int i = 0; i < 8; i++) rd("R1 fiq", 4'(i), 32'h1000_0000 + i);
        rd("R1 pc fiq", 4'd15, 32'h0000_8000);
        set_mode(UND);
        wr(4'd4, 32'h4444_4444);
        set_mode(USR);
        rd("R1 user", 4'd4, 32'h4444_4444);
        rd("R1 pc user", 4'd15, 32'h0000_8000);
    endtask

    task automatic t_fast_bank();
        set_mode(USR);
        for (int i = 8; i <= 12; i++) wr(4'(i), 32'hA000_0000 + i);
        set_mode(FIQ);
        for (int i = 8; i <= 12; i++) rd("R2 fiq fresh", 4'(i), 32'h0);
        for (int i = 8; i <= 12; i++) wr(4'(i), 32'hB000_0000 + i);
        set_mode(IRQ);
        for (int i = 8; i <= 12; i++) rd("R2 irq shares user", 4'(i), 32'hA000_0000 + i);
        set_mode(FIQ);
        for (int i = 8; i <= 12; i++) rd("R2 fiq kept", 4'(i), 32'hB000_0000 + i);
    endtask

    task automatic t_sp_lr();
        logic [3:0] ml[5] = '{FIQ, IRQ, SVC, ABT, UND};
        set_mode(USR);
        wr(4'd13, 32'h5500_0013); wr(4'd14, 32'h5500_0014);
        foreach (ml[k]) begin
            set_mode(ml[k]);
            wr(4'd13, {16'h1300, 12'h0, ml[k]});
            wr(4'd14, {16'h1400, 12'h0, ml[k]});
        end
        foreach (ml[k]) begin
            set_mode(ml[k]);
            rd("R3 private sp", 4'd13, {16'h1300, 12'h0, ml[k]});
            rd("R3 private lr", 4'd14, {16'h1400, 12'h0, ml[k]});
        end
        set_mode(ODD);
        rd("R3 unlisted sp", 4'd13, 32'h5500_0013);
        rd("R3 unlisted lr", 4'd14, 32'h5500_0014);
        rd("R2 unlisted r8", 4'd8, 32'hA000_0008);
    endtask

    task automatic t_saved();
        logic [3:0] ml[5] = '{FIQ, IRQ, SVC, ABT, UND};
        foreach (ml[k]) begin
            set_mode(ml[k]);
            ssr_wr({20'h5A5A5, 8'h0, ml[k]});
        end
        foreach (ml[k]) begin
            set_mode(ml[k]);
            #1;
            chk("R4 ssr", ssr_rd_data, {20'h5A5A5, 8'h0, ml[k]});
            chk("R4 present", {31'h0, ssr_absent}, 32'h0);
        end
    endtask

    task automatic t_no_saved();
        set_mode(USR);
        ssr_wr(32'hDEAD_BEEF);
        #1;
        chk("R5 user ssr zero", ssr_rd_data, 32'h0);
        chk("R5 user absent", {31'h0, ssr_absent}, 32'h1);
        set_mode(ODD);
        ssr_wr(32'hCAFE_F00D);
        #1;
        chk("R5 unlisted absent", {31'h0, ssr_absent}, 32'h1);
        chk("R5 unlisted zero", ssr_rd_data, 32'h0);
        set_mode(SVC);
        #1;
        chk("R5 svc untouched", ssr_rd_data, {20'h5A5A5, 8'h0, SVC});
        set_mode(FIQ);
        #1;
        chk("R5 fiq untouched", ssr_rd_data, {20'h5A5A5, 8'h0, FIQ});
    endtask

    task automatic t_mode_field();
        sr_wr_en = 1'b1; sr_wr_data = 32'hF000_00C0;
        tick();
        sr_wr_en = 1'b0;
        chk("R7 full write", sr_q, 32'hF000_00C0);
        set_mode(IRQ);
        chk("R6 upper kept", sr_q, 32'hF000_00D2);
        chk("R6 mode field", {27'h0, mode_field}, 32'h12);
        sr_wr_en = 1'b1; sr_wr_data = 32'h0000_00FF;
        mode_set = 1'b1; mode_code = SVC;
        tick();
        sr_wr_en = 1'b0; mode_set = 1'b0;
        chk("R7 mode set wins", sr_q, 32'h0000_00F3);
        chk("R7 mode field", {27'h0, mode_field}, 32'h13);
    endtask

    task automatic t_write_on_switch();
        set_mode(FIQ);
        wr(4'd13, 32'h0F0F_0013);
        set_mode(USR);
        wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'h7777_0013;
        ssr_wr_en = 1'b1; ssr_wr_data = 32'h1234_5678;
        mode_set = 1'b1; mode_code = FIQ;
        tick();
        wr_en = 1'b0; mode_set = 1'b0; ssr_wr_en = 1'b0;
        rd("R8 fiq sp untouched", 4'd13, 32'h0F0F_0013);
        #1;
        chk("R8 fiq ssr untouched", ssr_rd_data, {20'h5A5A5, 8'h0, FIQ});
        set_mode(USR);
        rd("R8 user sp written", 4'd13, 32'h7777_0013);
        set_mode(IRQ);
        ssr_wr_en = 1'b1; ssr_wr_data = 32'h0BAD_0002;
        mode_set = 1'b1; mode_code = USR;
        tick();
        ssr_wr_en = 1'b0; mode_set = 1'b0;
        set_mode(IRQ);
        #1;
        chk("R8 old mode ssr written", ssr_rd_data, 32'h0BAD_0002);
    endtask

    task automatic t_read_during_write();
        set_mode(USR);
        wr(4'd3, 32'h0000_0333);
        wr(4'd6, 32'h0000_0666);
        rd_a_addr = 4'd3; rd_b_addr = 4'd6;
        wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h9999_0003;
        #1;
        chk("R9 old before edge", rd_a_data, 32'h0000_0333);
        chk("R11 port b other reg", rd_b_data, 32'h0000_0666);
        tick();
        wr_en = 1'b0;
        #1;
        chk("R9 new after edge", rd_a_data, 32'h9999_0003);
        chk("R11 port b unchanged", rd_b_data, 32'h0000_0666);
        rd_a_addr = 4'd15; rd_b_addr = 4'd4;
        #1;
        chk("R11 port a pc", rd_a_data, 32'h0000_8000);
        chk("R11 port b r4", rd_b_data, 32'h4444_4444);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        t_reset_state();
        set_mode(FIQ);
        rd("R10 fiq r8", 4'd8, 32'h0);
        rd("R10 fiq sp", 4'd13, 32'h0);
        #1;
        chk("R10 fiq ssr", ssr_rd_data, 32'h0);
        set_mode(SVC);
        rd("R10 svc lr", 4'd14, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_shared();
        t_fast_bank();
        t_sp_lr();
        t_saved();
        t_no_saved();
        t_mode_field();
        t_write_on_switch();
        t_read_during_write();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule